// File: doc/BRIEF.md
# Flash Page-Program Write Buffer

This block gathers one page of flash data from a stream of 32-bit host words and then sends it to a serial NOR flash in a single page-program frame. The storage is shared with a read-prefetch function. A mode bit decides which role the storage has. The new mode is reported back only after the switch has settled, so software writes the bit and then polls it until it reads back the value it wrote.

Software first writes the three address byte registers and sets the mode bit to program. It then streams up to 32 words into the data port and writes the program command code. The block drives a frame of the form opcode 0x02, then the 24-bit address, then the buffered bytes. The command bit clears itself when chip select rises. The write-enable command that must precede the frame is the job of software.

The data port is a valid/ready stream. A word moves on a clock edge where both `wd_valid` and `wd_ready` are high. `wd_ready` drops for the whole of a frame, which is the only back-pressure the port applies. When ready is high, every word offered is taken. A word taken in read mode, or once the page is full, is thrown away and does not stall the port.

Top module: `pp_write_buffer`

## Requirements
- R1: After reset, `mode_rd` is 0, `cmd_busy` is 0, `spi_cs_n` is 1, `spi_sclk` is 0 and `wd_ready` is 1.
- R2: A mode write (`mode_wr_en` with `mode_wr_val`) shows up on `mode_rd` exactly SW_LAT clock edges later when no frame is in progress. A mode write made during a frame takes effect SW_LAT edges after the frame ends, and `mode_rd` holds steady for the whole frame.
- R3: A data word moves on an edge where `wd_valid` and `wd_ready` are both high. `wd_ready` is low while a frame is in progress and high at all other times.
- R4: Words taken while `mode_rd` is 0 are discarded and never appear in a frame.
- R5: At most 32 words (128 bytes) are kept per page. Words offered after that are taken and dropped.
- R6: A command write with code 0x10 while in program mode and idle starts a frame, and `cmd_busy` is high from the next cycle until chip select rises. Any other code, or code 0x10 in read mode, is ignored.
- R7: The frame sends the opcode 0x02 first, then address bits 23:0 most significant byte first. Every byte goes out MSB first. Data is valid on the rising edge of `spi_sclk`, and `spi_sclk` idles low while `spi_cs_n` is high.
- R8: Within each buffered word, bits 7:0 are sent first, then bits 15:8, 23:16 and 31:24. Words go out in the order they were taken.
- R9: When fewer than 32 words are buffered, the frame carries only those bytes. With none buffered, it carries only the opcode and the address.
- R10: The fill pointer returns to zero when a frame completes and when the mode bit changes from 1 to 0, so the next page starts at word 0.
- R11: `addr_wr_en[i]` loads address byte i from `addr_wr_data[8*i+7:8*i]`. Bytes that are not enabled keep their value.
- R12: A word taken in the same cycle as a starting command is included as the last word of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr_en | input | 1 | Mode bit write strobe |
| mode_wr_val | input | 1 | Requested mode: 0 read prefetch, 1 page program |
| mode_rd | output | 1 | Mode bit readback, reflects the mode in effect |
| addr_wr_en | input | 3 | Per-byte address register write enables |
| addr_wr_data | input | 24 | Address byte write data |
| cmd_wr_en | input | 1 | Command register write strobe |
| cmd_wr_data | input | 8 | Command code, 0x10 starts programming |
| cmd_busy | output | 1 | Command bit readback, clears when the frame ends |
| wd_valid | input | 1 | Data word valid |
| wd_ready | output | 1 | Data word ready |
| wd_data | input | 32 | Little-endian data word |
| spi_sclk | output | 1 | Serial clock to flash |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to flash |

## Verification
The collision that matters here is a start command arriving in the same clock cycle as a data word being taken. The bench offers the last word of a partial page together with the 0x10 command write. It then checks that the frame length and the bytes on the wire include that word. A second kind of overlap is a mode write made while a frame is running. The bench issues such a write mid-frame and checks three things: `mode_rd` stays unchanged until chip select rises, it still holds just after, and it changes SW_LAT edges later.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam logic [7:0] CMD_PROGRAM = 8'h10;
  localparam logic [7:0] FLASH_OP_PP = 8'h02;
  typedef enum logic {SH_IDLE, SH_RUN} sh_state_e;
endpackage

// File: rtl/pp_mode_ctrl.sv
module pp_mode_ctrl #(
  parameter int SW_LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_val,
  input  logic busy,
  output logic mode,
  output logic mode_fall
);
  localparam int LW = $clog2(SW_LAT + 1);

  logic          req_q;
  logic          pend_q;
  logic [LW-1:0] cnt_q;

  // A requested role change waits for the serializer to go idle,
  // then drains for SW_LAT edges before it is reported.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= 1'b0;
      req_q     <= 1'b0;
      pend_q    <= 1'b0;
      cnt_q     <= '0;
      mode_fall <= 1'b0;
    end else begin
      mode_fall <= 1'b0;
      if (wr_en) begin
        req_q  <= wr_val;
        pend_q <= 1'b1;
        cnt_q  <= '0;
      end else if (pend_q && !busy) begin
        if (cnt_q == LW'(SW_LAT - 1)) begin
          mode      <= req_q;
          pend_q    <= 1'b0;
          mode_fall <= mode & ~req_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pp_page_buf.sv
module pp_page_buf #(
  parameter int PAGE_BYTES = 128
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              take,
  input  logic                              store_en,
  input  logic [31:0]                       wdata,
  input  logic                              clr,
  input  logic [$clog2(PAGE_BYTES)-1:0]     rd_idx,
  output logic [7:0]                        rd_byte,
  output logic [$clog2(PAGE_BYTES/4+1)-1:0] fill
);
  localparam int WORDS = PAGE_BYTES / 4;
  localparam int AW    = $clog2(WORDS);
  localparam int FW    = $clog2(WORDS + 1);

  logic [31:0] mem [WORDS];
  logic        room;
  logic [7:0]  lane [4];
  logic [31:0] rd_word;

  assign room = (fill < FW'(WORDS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0;
    end else if (clr) begin
      fill <= '0;
    end else if (take && store_en && room) begin
      fill <= fill + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take && store_en && room) begin
      mem[fill[AW-1:0]] <= wdata;
    end
  end

  assign rd_word = mem[rd_idx[$clog2(PAGE_BYTES)-1:2]];

  // Little-endian lanes: lane 0 is the lowest-addressed byte.
  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign lane[g] = rd_word[8*g +: 8];
  end

  assign rd_byte = lane[rd_idx[1:0]];
endmodule

// File: rtl/pp_frame_tx.sv
module pp_frame_tx
  import pp_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int HDR_BYTES  = 4,
  parameter int CLK_HALF   = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic [8*HDR_BYTES-1:0]            hdr,
  input  logic [$clog2(PAGE_BYTES+1)-1:0]   nbytes,
  input  logic [7:0]                        rd_byte,
  output logic [$clog2(PAGE_BYTES)-1:0]     rd_idx,
  output logic                              busy,
  output logic                              done,
  output logic                              sclk,
  output logic                              cs_n,
  output logic                              mosi
);
  localparam int BCW = $clog2(PAGE_BYTES + HDR_BYTES);
  localparam int DW  = $clog2(CLK_HALF + 1);
  localparam int IW  = $clog2(PAGE_BYTES);
  localparam int HW  = 8 * HDR_BYTES;

  sh_state_e      state_q;
  logic [HW-1:0]  hdr_q;
  logic [BCW-1:0] byte_q;
  logic [BCW-1:0] last_q;
  logic [2:0]     bit_q;
  logic [DW-1:0]  div_q;
  logic           in_hdr;
  logic           half_end;
  logic [7:0]     cur_byte;

  assign in_hdr   = (byte_q < BCW'(HDR_BYTES));
  assign half_end = (div_q == DW'(CLK_HALF - 1));
  assign rd_idx   = IW'(byte_q - BCW'(HDR_BYTES));
  assign cur_byte = in_hdr ? hdr_q[HW-1 -: 8] : rd_byte;
  assign busy     = (state_q == SH_RUN);
  assign mosi     = busy ? cur_byte[3'd7 - bit_q] : 1'b0;
  assign done     = busy && half_end && sclk && (bit_q == 3'd7) && (byte_q == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_IDLE;
      hdr_q   <= '0;
      byte_q  <= '0;
      last_q  <= '0;
      bit_q   <= '0;
      div_q   <= '0;
      sclk    <= 1'b0;
      cs_n    <= 1'b1;
    end else begin
      case (state_q)
        SH_IDLE: begin
          if (start) begin
            state_q <= SH_RUN;
            cs_n    <= 1'b0;
            sclk    <= 1'b0;
            div_q   <= '0;
            bit_q   <= '0;
            byte_q  <= '0;
            hdr_q   <= hdr;
            last_q  <= BCW'(nbytes) + BCW'(HDR_BYTES - 1);
          end
        end
        default: begin
          if (half_end) begin
            div_q <= '0;
            if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              if (bit_q == 3'd7) begin
                bit_q <= '0;
                if (byte_q == last_q) begin
                  state_q <= SH_IDLE;
                  cs_n    <= 1'b1;
                end else begin
                  byte_q <= byte_q + 1'b1;
                  if (in_hdr) hdr_q <= hdr_q << 8;
                end
              end else begin
                bit_q <= bit_q + 1'b1;
              end
            end
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pp_write_buffer.sv
module pp_write_buffer
  import pp_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int ADDR_BYTES = 3,
  parameter int CLK_HALF   = 2,
  parameter int SW_LAT     = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_wr_en,
  input  logic                    mode_wr_val,
  output logic                    mode_rd,
  input  logic [ADDR_BYTES-1:0]   addr_wr_en,
  input  logic [8*ADDR_BYTES-1:0] addr_wr_data,
  input  logic                    cmd_wr_en,
  input  logic [7:0]              cmd_wr_data,
  output logic                    cmd_busy,
  input  logic                    wd_valid,
  output logic                    wd_ready,
  input  logic [31:0]             wd_data,
  output logic                    spi_sclk,
  output logic                    spi_cs_n,
  output logic                    spi_mosi
);
  localparam int WORDS     = PAGE_BYTES / 4;
  localparam int FW        = $clog2(WORDS + 1);
  localparam int NBW       = $clog2(PAGE_BYTES + 1);
  localparam int IW        = $clog2(PAGE_BYTES);
  localparam int HDR_BYTES = 1 + ADDR_BYTES;

  logic [8*ADDR_BYTES-1:0] addr_q;
  logic [FW-1:0]           fill_words;
  logic [FW-1:0]           fill_next;
  logic                    take;
  logic                    keep;
  logic                    start;
  logic                    done;
  logic                    mode_fall;
  logic [IW-1:0]           rd_idx;
  logic [7:0]              rd_byte;
  logic [NBW-1:0]          nbytes;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             addr_q[8*g +: 8] <= '0;
      else if (addr_wr_en[g]) addr_q[8*g +: 8] <= addr_wr_data[8*g +: 8];
    end
  end

  assign wd_ready  = !cmd_busy;
  assign take      = wd_valid && wd_ready;
  assign keep      = take && mode_rd && (fill_words < FW'(WORDS));
  assign fill_next = fill_words + FW'(keep);
  assign nbytes    = NBW'({fill_next, 2'b00});
  assign start     = cmd_wr_en && (cmd_wr_data == CMD_PROGRAM) && mode_rd && !cmd_busy;

  pp_mode_ctrl #(.SW_LAT(SW_LAT)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (mode_wr_en),
    .wr_val    (mode_wr_val),
    .busy      (cmd_busy),
    .mode      (mode_rd),
    .mode_fall (mode_fall)
  );

  pp_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .store_en (mode_rd),
    .wdata    (wd_data),
    .clr      (done | mode_fall),
    .rd_idx   (rd_idx),
    .rd_byte  (rd_byte),
    .fill     (fill_words)
  );

  pp_frame_tx #(
    .PAGE_BYTES (PAGE_BYTES),
    .HDR_BYTES  (HDR_BYTES),
    .CLK_HALF   (CLK_HALF)
  ) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .hdr     ({FLASH_OP_PP, addr_q}),
    .nbytes  (nbytes),
    .rd_byte (rd_byte),
    .rd_idx  (rd_idx),
    .busy    (cmd_busy),
    .done    (done),
    .sclk    (spi_sclk),
    .cs_n    (spi_cs_n),
    .mosi    (spi_mosi)
  );
endmodule

// File: rtl/pp_write_buffer_chk.sv
module pp_write_buffer_chk #(
  parameter int WORDS = 32,
  parameter int FW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_rd,
  input logic          cmd_wr_en,
  input logic [7:0]    cmd_wr_data,
  input logic          cmd_busy,
  input logic          wd_ready,
  input logic          spi_sclk,
  input logic          spi_cs_n,
  input logic [FW-1:0] fill_words
);
  assert_no_accept_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_busy |-> !wd_ready);

  assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_words <= FW'(WORDS));

  assert_read_mode_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_en && !mode_rd && !cmd_busy) |=> !cmd_busy);

  assert_bad_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_en && cmd_wr_data != 8'h10 && !cmd_busy) |=> !cmd_busy);

  assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_busy |=> $stable(mode_rd));

  assert_ptr_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_busy) |-> (fill_words == '0));
endmodule

bind pp_write_buffer pp_write_buffer_chk #(.WORDS(WORDS), .FW(FW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_rd     (mode_rd),
  .cmd_wr_en   (cmd_wr_en),
  .cmd_wr_data (cmd_wr_data),
  .cmd_busy    (cmd_busy),
  .wd_ready    (wd_ready),
  .spi_sclk    (spi_sclk),
  .spi_cs_n    (spi_cs_n),
  .fill_words  (fill_words)
);

// File: tb/pp_write_buffer_test.sv
module pp_write_buffer_test;
  localparam int PAGE  = 128;
  localparam int WORDS = PAGE / 4;
  localparam int LAT   = 4;
  localparam int MAXB  = 8 * (PAGE + 4);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr_en = 1'b0, mode_wr_val = 1'b0;
  logic        mode_rd;
  logic [2:0]  addr_wr_en = '0;
  logic [23:0] addr_wr_data = '0;
  logic        cmd_wr_en = 1'b0;
  logic [7:0]  cmd_wr_data = '0;
  logic        cmd_busy;
  logic        wd_valid = 1'b0;
  logic        wd_ready;
  logic [31:0] wd_data = '0;
  logic        spi_sclk, spi_cs_n, spi_mosi;

  always #5 clk = ~clk;

  pp_write_buffer uut (
    .clk(clk), .rst_n(rst_n),
    .mode_wr_en(mode_wr_en), .mode_wr_val(mode_wr_val), .mode_rd(mode_rd),
    .addr_wr_en(addr_wr_en), .addr_wr_data(addr_wr_data),
    .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data), .cmd_busy(cmd_busy),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
  );

  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;
  logic cap [MAXB];
  int   ncap = 0;
  logic [7:0] exp_b [PAGE + 4];

  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      if (ncap < MAXB) cap[ncap] = spi_mosi;
      ncap++;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] pb(input int i, input int seed);
    return 8'(i * 7 + seed * 29 + 3);
  endfunction

  function automatic logic [31:0] word_of(input int k, input int seed);
    return {pb(4*k+3, seed), pb(4*k+2, seed), pb(4*k+1, seed), pb(4*k, seed)};
  endfunction

  // All tasks start and end just after a falling clock edge.
  task automatic push(input logic [31:0] w);
    wd_valid = 1'b1; wd_data = w;
    @(negedge clk);
    wd_valid = 1'b0;
  endtask

  task automatic fill(input int n, input int seed);
    for (int k = 0; k < n; k++) push(word_of(k, seed));
  endtask

  task automatic set_mode(input logic v);
    mode_wr_en = 1'b1; mode_wr_val = v;
    @(negedge clk);
    mode_wr_en = 1'b0;
    repeat (LAT) @(negedge clk);
  endtask

  task automatic set_addr(input logic [23:0] a);
    addr_wr_en = 3'b111; addr_wr_data = a;
    @(negedge clk);
    addr_wr_en = '0;
  endtask

  task automatic wait_idle();
    while (cmd_busy) @(negedge clk);
  endtask

  task automatic run_cmd(input string req);
    ncap = 0;
    cmd_wr_en = 1'b1; cmd_wr_data = 8'h10;
    @(negedge clk);
    cmd_wr_en = 1'b0;
    chk(req, "busy after start", cmd_busy, 1'b1);
    chk("R3", "ready during frame", wd_ready, 1'b0);
    wait_idle();
    @(negedge clk);
  endtask

  task automatic expect_frame(input string req, input logic [23:0] a, input int nbytes, input int seed);
    int bad = 0;
    exp_b[0] = 8'h02; exp_b[1] = a[23:16]; exp_b[2] = a[15:8]; exp_b[3] = a[7:0];
    for (int i = 0; i < nbytes; i++) exp_b[4+i] = pb(i, seed);
    chk(req, "frame bit count", ncap, 8 * (4 + nbytes));
    for (int i = 0; i < 8 * (4 + nbytes) && i < ncap && i < MAXB; i++) begin
      if (cap[i] !== exp_b[i/8][7 - (i%8)]) bad++;
    end
    chk(req, "frame bit mismatches", bad, 0);
  endtask

  task automatic t_reset();
    chk("R1", "mode_rd", mode_rd, 1'b0);
    chk("R1", "cmd_busy", cmd_busy, 1'b0);
    chk("R1", "cs_n", spi_cs_n, 1'b1);
    chk("R1", "sclk", spi_sclk, 1'b0);
    chk("R1", "wd_ready", wd_ready, 1'b1);
  endtask

  task automatic t_mode_switch();
    mode_wr_en = 1'b1; mode_wr_val = 1'b1;
    @(negedge clk);
    mode_wr_en = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    chk("R2", "mode before latency", mode_rd, 1'b0);
    @(negedge clk);
    chk("R2", "mode after latency", mode_rd, 1'b1);
  endtask

  task automatic t_full_page();
    set_addr(24'h123456);
    addr_wr_en = 3'b001; addr_wr_data = 24'hFFFF78;
    @(negedge clk);
    addr_wr_en = '0;
    chk("R3", "ready while filling", wd_ready, 1'b1);
    fill(WORDS, 1);
    run_cmd("R6");
    expect_frame("R8", 24'h123478, PAGE, 1);
    chk("R11", "busy cleared", cmd_busy, 1'b0);
  endtask

  task automatic t_ptr_after_done();
    run_cmd("R10");
    expect_frame("R10", 24'h123478, 0, 0);
  endtask

  task automatic t_overflow();
    fill(WORDS, 2);
    push(32'hDEADBEEF);
    run_cmd("R5");
    expect_frame("R5", 24'h123478, PAGE, 2);
  endtask

  task automatic t_partial();
    set_addr(24'h00A0C0);
    fill(5, 3);
    run_cmd("R9");
    expect_frame("R9", 24'h00A0C0, 20, 3);
  endtask

  task automatic t_read_mode();
    set_mode(1'b0);
    fill(3, 9);
    cmd_wr_en = 1'b1; cmd_wr_data = 8'h10;
    @(negedge clk);
    cmd_wr_en = 1'b0;
    chk("R6", "read-mode cmd ignored", cmd_busy, 1'b0);
    chk("R6", "cs_n stays high", spi_cs_n, 1'b1);
    set_mode(1'b1);
    fill(1, 4);
    run_cmd("R4");
    expect_frame("R4", 24'h00A0C0, 4, 4);
  endtask

  task automatic t_bad_code();
    fill(2, 5);
    cmd_wr_en = 1'b1; cmd_wr_data = 8'h11;
    @(negedge clk);
    cmd_wr_en = 1'b0;
    chk("R6", "other code ignored", cmd_busy, 1'b0);
    run_cmd("R6");
    expect_frame("R6", 24'h00A0C0, 8, 5);
  endtask

  task automatic t_mode_clear();
    fill(2, 6);
    set_mode(1'b0);
    set_mode(1'b1);
    fill(1, 7);
    run_cmd("R10");
    expect_frame("R10", 24'h00A0C0, 4, 7);
  endtask

  task automatic t_same_cycle();
    fill(3, 8);
    ncap = 0;
    wd_valid = 1'b1; wd_data = word_of(3, 8);
    cmd_wr_en = 1'b1; cmd_wr_data = 8'h10;
    @(negedge clk);
    wd_valid = 1'b0; cmd_wr_en = 1'b0;
    chk("R12", "busy after start", cmd_busy, 1'b1);
    wait_idle();
    @(negedge clk);
    expect_frame("R12", 24'h00A0C0, 16, 8);
  endtask

  task automatic t_deferred_mode();
    set_addr(24'h0F0E0D);
    fill(4, 10);
    ncap = 0;
    cmd_wr_en = 1'b1; cmd_wr_data = 8'h10;
    @(negedge clk);
    cmd_wr_en = 1'b0;
    repeat (5) @(negedge clk);
    mode_wr_en = 1'b1; mode_wr_val = 1'b0;
    @(negedge clk);
    mode_wr_en = 1'b0;
    repeat (2 * LAT) @(negedge clk);
    chk("R2", "mode held during frame", mode_rd, 1'b1);
    wait_idle();
    chk("R2", "mode just after frame", mode_rd, 1'b1);
    repeat (LAT) @(negedge clk);
    chk("R2", "mode after deferred switch", mode_rd, 1'b0);
    expect_frame("R7", 24'h0F0E0D, 16, 10);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_switch();
    t_full_page();
    t_ptr_after_done();
    t_overflow();
    t_partial();
    t_read_mode();
    t_bad_code();
    t_mode_clear();
    t_same_cycle();
    t_deferred_mode();
    finish_run();
  end
endmodule